// File: doc/BRIEF.md
# Serial Control and Status Slave (LSB-first)

This block is the serial front end of a power-driver controller. A host microcontroller selects it with an active-low chip select and clocks in a 16-bit control word, least significant bit first. The word is kept in a control register that the rest of the chip uses. During the same transfer, the block returns one of two 16-bit diagnostic frames, also least significant bit first. Bit 0 of the control register that was already in place before the transfer chooses which frame is returned.

The serial pins are synchronised into the fast system clock and edge-detected, so all of the logic runs in one clock domain. When chip select goes low, the data output is enabled at once. Before any serial clock edge it shows a summary fault flag, which is the OR of every diagnostic flag. This lets the host poll for faults without running a full transfer. A committed word with its top bit set raises a one-cycle clear strobe toward the status logic.

Top module: `spi_ctrl_slave`

## Requirements
- R1: `sdoOe` is 0 while chip select is high and 1 while it is low, after the synchroniser delay.
- R2: While chip select is low and no rising serial clock edge has yet arrived, `sdo` equals the fault flag. The fault flag is the OR of all bits of `stat0Flags` and `stat1Flags`, and `sdo` follows changes of those inputs.
- R3: The first rising serial clock edge of a transfer loads the outgoing frame, and each later falling edge moves `sdo` to the next bit. Frame 0 is {1, stat0Flags[13:0], fault}, with bit 15 first in that list. Frame 1 is {1, 0, stat1Flags[12:0], fault}. Frame bit k is on `sdo` after k falling edges.
- R4: `sdi` is sampled on rising serial clock edges, and the first bit received becomes bit 0. `ctrlWord` takes the received word only when chip select rises.
- R5: Both serial clock idle levels work: clock idling low (mode 0) and clock idling high (mode 3). In mode 3, a falling edge before the first rising edge does not shift the frame.
- R6: Only the first 16 received bits count. Any later bits change neither `ctrlWord` nor the frame.
- R7: A transfer with fewer than 16 rising edges leaves `ctrlWord` unchanged and raises no clear strobe.
- R8: When a committed word has bit 15 set, `clearStat` is high for exactly one cycle, in the same cycle that `ctrlWord` changes.
- R9: If the last rising serial clock edge and the chip-select rise reach the block in the same system cycle, the committed word still holds all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, LSB first |
| stat0Flags | input | 14 | Flags for frame 0, bits 14..1 |
| stat1Flags | input | 13 | Flags for frame 1, bits 13..1 |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the `sdo` pad driver |
| ctrlWord | output | 16 | Control register, updated at the end of a transfer |
| clearStat | output | 1 | One-cycle clear strobe toward the status logic |

## Verification
The 16th data sample and the chip-select rise can be detected in the same system cycle. The commit must then take the shift value that already includes that last bit. The bench provokes this by driving the final serial clock rise and the chip-select rise at the same instant in mode 0. It then checks that `ctrlWord` equals the whole word, and that the clear strobe appears exactly when bit 15 is set. Randomised transfers mix 16-bit, short and over-long frames in both clock modes, so ordinary end-of-frame timing is checked against the same model.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // Strobes and state passed from the control module to the datapath
  typedef struct packed {
    logic csActive;   // chip select low (synchronised)
    logic loaded;     // outgoing frame loaded in this transfer
    logic sdiBit;     // synchronised data bit
    logic sampleBit;  // take sdiBit into the input shifter
    logic loadOut;    // copy the selected frame into the output shifter
    logic shiftOut;   // advance the output shifter
    logic commit;     // move the received word into the control register
  } spiStrobe_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int WORD        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output spiStrobe_t stb
);

  localparam int CNT_W = $clog2(WORD + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD);

  logic csQ, clkQ, sdiQ;
  logic csPrev, clkPrev;
  logic csRise, csFall, clkRise, clkFall, inFrame;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic loaded;
  logic sampleBit, loadOut, shiftOut, commit;

  spi_slv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncCs (
    .clk(clk), .rstN(rstN), .d(csN), .q(csQ));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncClk (
    .clk(clk), .rstN(rstN), .d(sclk), .q(clkQ));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncDi (
    .clk(clk), .rstN(rstN), .d(sdi), .q(sdiQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      clkPrev <= 1'b0;
    end else begin
      csPrev  <= csQ;
      clkPrev <= clkQ;
    end
  end

  assign csRise  = csQ & ~csPrev;
  assign csFall  = ~csQ & csPrev;
  assign clkRise = clkQ & ~clkPrev;
  assign clkFall = ~clkQ & clkPrev;
  // the cycle in which chip select rises still belongs to the frame
  assign inFrame = ~csQ | ~csPrev;

  assign sampleBit = clkRise & inFrame & (bitCnt < FULL);
  assign cntNext   = bitCnt + {{(CNT_W-1){1'b0}}, sampleBit};
  assign commit    = csRise & (cntNext == FULL);
  assign loadOut   = clkRise & ~csQ & ~loaded;
  assign shiftOut  = clkFall & ~csQ & loaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      loaded <= 1'b0;
    end else if (csRise || csFall) begin
      bitCnt <= '0;
      loaded <= 1'b0;
    end else begin
      bitCnt <= cntNext;
      if (loadOut) loaded <= 1'b1;
    end
  end

  always_comb begin
    stb.csActive  = ~csQ;
    stb.loaded    = loaded;
    stb.sdiBit    = sdiQ;
    stb.sampleBit = sampleBit;
    stb.loadOut   = loadOut;
    stb.shiftOut  = shiftOut;
    stb.commit    = commit;
  end

endmodule

// File: rtl/spi_slv_dpath.sv
module spi_slv_dpath
  import spi_slv_pkg::*;
#(
  parameter int WORD = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobe_t       stb,
  input  logic [WORD-3:0]  stat0Flags,
  input  logic [WORD-4:0]  stat1Flags,
  output logic             sdo,
  output logic             sdoOe,
  output logic [WORD-1:0]  ctrlWord,
  output logic             clearStat
);

  logic fault, faultQ;
  logic [WORD-1:0] frame0, frame1, frameSel;
  logic [WORD-1:0] inShift, inNext, outShift;

  assign fault  = (|stat0Flags) | (|stat1Flags);
  // top bit fixed high; frame 1 also has a fixed low bit below it
  assign frame0 = {1'b1, stat0Flags, fault};
  assign frame1 = {1'b1, 1'b0, stat1Flags, fault};
  assign frameSel = ctrlWord[0] ? frame1 : frame0;

  assign inNext = stb.sampleBit ? {stb.sdiBit, inShift[WORD-1:1]} : inShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift   <= '0;
      outShift  <= '0;
      ctrlWord  <= '0;
      clearStat <= 1'b0;
      faultQ    <= 1'b0;
    end else begin
      inShift   <= inNext;
      faultQ    <= fault;
      clearStat <= stb.commit & inNext[WORD-1];
      if (stb.commit) ctrlWord <= inNext;
      if (stb.loadOut)       outShift <= frameSel;
      else if (stb.shiftOut) outShift <= {1'b0, outShift[WORD-1:1]};
    end
  end

  assign sdo   = stb.loaded ? outShift[0] : faultQ;
  assign sdoOe = stb.csActive;

endmodule

// File: rtl/spi_ctrl_slave.sv
module spi_ctrl_slave
  import spi_slv_pkg::*;
#(
  parameter int WORD        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sclk,
  input  logic            sdi,
  input  logic [WORD-3:0] stat0Flags,
  input  logic [WORD-4:0] stat1Flags,
  output logic            sdo,
  output logic            sdoOe,
  output logic [WORD-1:0] ctrlWord,
  output logic            clearStat
);

  spiStrobe_t stb;

  spi_slv_ctrl #(.WORD(WORD), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .stb(stb));

  spi_slv_dpath #(.WORD(WORD)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .stat0Flags(stat0Flags), .stat1Flags(stat1Flags),
    .sdo(sdo), .sdoOe(sdoOe), .ctrlWord(ctrlWord), .clearStat(clearStat));

endmodule

// File: rtl/spi_ctrl_slave_chk.sv
module spi_ctrl_slave_chk #(
  parameter int WORD = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            sdoOe,
  input logic            clearStat,
  input logic [WORD-1:0] ctrlWord,
  input logic            commit,
  input logic            loaded,
  input logic            loadOut
);

  // R8: the clear strobe lasts a single cycle
  p_clear_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearStat |=> !clearStat);

  // R8: the clear strobe comes with a committed word whose top bit is set
  p_clear_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearStat |-> ctrlWord[WORD-1]);

  // R4: the control register changes only after a commit
  p_ctrl_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlWord) |-> $past(commit));

  // R4: a commit happens only once the output driver is off
  p_commit_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !sdoOe);

  // R3: a load marks the frame as loaded
  p_load_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadOut |=> loaded);

  // R2: every new selection starts in fault-poll state
  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && !$past(sdoOe)) |-> !loaded);

endmodule

bind spi_ctrl_slave spi_ctrl_slave_chk #(.WORD(WORD)) u_chk (
  .clk(clk), .rstN(rstN), .sdoOe(sdoOe), .clearStat(clearStat),
  .ctrlWord(ctrlWord), .commit(stb.commit), .loaded(stb.loaded),
  .loadOut(stb.loadOut));

// File: tb/spi_ctrl_slave_tb.sv
module spi_ctrl_slave_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [13:0] stat0Flags = '0;
  logic [12:0] stat1Flags = '0;
  logic sdo, sdoOe, clearStat;
  logic [15:0] ctrlWord;

  int checks = 0;
  int errors = 0;
  int clrCnt = 0;
  bit done = 0;
  logic [15:0] modelCtrl = '0;

  always #2 clk = ~clk;

  spi_ctrl_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .stat0Flags(stat0Flags), .stat1Flags(stat1Flags),
    .sdo(sdo), .sdoOe(sdoOe), .ctrlWord(ctrlWord), .clearStat(clearStat));

  always @(negedge clk) if (rstN && clearStat) clrCnt++;

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic faultOf(input logic [13:0] f0, input logic [12:0] f1);
    return (|f0) | (|f1);
  endfunction

  function automatic logic [15:0] frameOf(input logic sel, input logic [13:0] f0,
                                          input logic [12:0] f1);
    logic ft = faultOf(f0, f1);
    return sel ? {1'b1, 1'b0, f1, ft} : {1'b1, f0, ft};
  endfunction

  // one transfer; mode3 = clock idles high; together = last rise with CS rise
  task automatic xfer(input logic [15:0] word, input int nbits, input bit mode3,
                      input bit together, input string req);
    logic [15:0] expFrame, got, mask;
    int clr0;
    bit full;
    expFrame = frameOf(modelCtrl[0], stat0Flags, stat1Flags);
    got = '0; mask = '0;
    clr0 = clrCnt;
    full = (nbits >= 16);
    sclk = mode3;
    waitc(8);
    csN = 1'b0;
    waitc(8);
    check(sdoOe == 1'b1, "R1", "oe when selected", sdoOe, 1);
    check(sdo == faultOf(stat0Flags, stat1Flags), "R2", "poll bit", sdo,
          faultOf(stat0Flags, stat1Flags));
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi = (i < 16) ? word[i] : 1'($urandom % 2);
      waitc(8);
      if (together && i == nbits - 1) begin
        sclk = 1'b1;
        csN = 1'b1;
        break;
      end
      sclk = 1'b1;
      waitc(8);
      if (i < 16) begin
        got[i] = sdo;
        mask[i] = 1'b1;
      end
    end
    if (!together) begin
      if (!mode3) begin
        sclk = 1'b0;
        waitc(8);
      end
      csN = 1'b1;
    end
    waitc(8);
    if (together) begin
      sclk = 1'b0;
      waitc(8);
    end
    if (full) modelCtrl = word;
    check((got & mask) == (expFrame & mask), req, "out frame",
          got & mask, expFrame & mask);
    check(ctrlWord == modelCtrl, req, "ctrlWord", ctrlWord, modelCtrl);
    check(clrCnt - clr0 == ((full && word[15]) ? 1 : 0), "R8", "clear pulses",
          clrCnt - clr0, (full && word[15]) ? 1 : 0);
    check(sdoOe == 1'b0, "R1", "oe after release", sdoOe, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    waitc(5);
    rstN = 1'b1;
    waitc(5);
    check(sdoOe == 1'b0, "R1", "reset oe", sdoOe, 0);
    check(ctrlWord == 16'h0, "R4", "reset ctrlWord", ctrlWord, 0);
    check(clearStat == 1'b0, "R8", "reset clear", clearStat, 0);

    // R2: fault poll follows the flags; R7: no clocks keeps ctrlWord
    stat0Flags = 14'h0040;
    csN = 1'b0;
    waitc(8);
    check(sdo == 1'b1, "R2", "poll fault set", sdo, 1);
    stat0Flags = '0;
    waitc(6);
    check(sdo == 1'b0, "R2", "poll fault cleared", sdo, 0);
    stat1Flags = 13'h1000;
    waitc(6);
    check(sdo == 1'b1, "R2", "poll reg1 flag", sdo, 1);
    csN = 1'b1;
    waitc(8);
    check(ctrlWord == 16'h0, "R7", "no clocks ctrlWord", ctrlWord, 0);

    // directed corners
    stat0Flags = 14'h2A5C; stat1Flags = 13'h0000;
    xfer(16'h1235, 16, 1'b0, 1'b0, "R4");   // selects frame 1 next
    stat0Flags = 14'h0000; stat1Flags = 13'h1FFF;
    xfer(16'h8002, 16, 1'b0, 1'b0, "R3");   // frame 1, clear strobe
    stat0Flags = 14'h0000; stat1Flags = 13'h0000;
    xfer(16'h4001, 16, 1'b1, 1'b0, "R5");   // mode 3, no fault
    stat0Flags = 14'h3FFF;
    xfer(16'hFFFE, 20, 1'b0, 1'b0, "R6");   // extra bits dropped
    xfer(16'h8888, 10, 1'b1, 1'b0, "R7");   // short frame
    xfer(16'h8F0F, 16, 1'b0, 1'b1, "R9");   // last edge with CS rise
    xfer(16'h0F0E, 16, 1'b0, 1'b1, "R9");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int nb;
      bit m3, tog;
      stat0Flags = 14'($urandom);
      stat1Flags = ($urandom % 4 == 0) ? 13'h0 : 13'($urandom);
      if ($urandom % 4 == 0) stat0Flags = '0;
      nb = 12 + int'($urandom % 9);
      m3 = 1'($urandom % 2);
      tog = (!m3 && nb == 16 && ($urandom % 2 == 1));
      xfer(16'($urandom), nb, m3, tog, m3 ? "R5" : "R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule